// File: doc/BRIEF.md
# Flash Query Response Lane Replicator

This block forms the read data returned when a bank of identical parallel flash devices is in table-query mode or identifier mode. A bus read address is scaled down to the device's native query offset, and that offset addresses a small external table ROM. The block then builds one device's answer and copies it into every device lane of the bank. When the access is wider than the bank, it repeats the lookup once per bank-width slice.

Bank width, device width and maximum (native) device width are each 1, 2 or 4 bytes. They are captured while reset is held. A device that runs narrower than its native width is supported only in byte mode. In that mode the table byte is repeated across the native width rather than padded with zeros. The ROM is read asynchronously through one address/data lane per bus byte. The response is registered and is returned one clock after the read strobe.

Top module: `flash_query_replicator`

## Requirements
- R1: The width codes `cfg_bank_lg`, `cfg_dev_lg` and `cfg_max_lg` give log2 of the byte count (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). They are captured on every clock edge where `rst_n` is low. Later changes to them have no effect on any response.
- R2: A read strobe `rd_en` sampled high produces `rd_valid` high for exactly the next cycle, with `rd_data` updated on that same edge. Without a strobe, `rd_valid` is low and `rd_data` keeps its value. Reset clears both.
- R3: The query offset for a lookup at address A is A shifted right by (bank code + max code − device code).
- R4: In query mode, an offset of 82 (0x52) or more gives zero for that bank slice.
- R5: In query mode with device code 0 and a max code above 0, every byte of the bank slice equals the table byte.
- R6: In query mode, a device code that is neither 0 nor equal to the max code gives an all-zero response.
- R7: In query mode with device code equal to max code, each device-width slice of the bank holds the table byte in its lowest byte and zeros above it.
- R8: The access size is 2^`rd_size_lg` bytes. Lookup i uses address `rd_addr` + i × bank bytes, and its bank slice starts at byte i × bank bytes. Bytes at or beyond the access size read as zero, including the case of an access narrower than the bank.
- R9: In identifier mode (`rd_id_mode`=1), bits [7:0] of the offset select the answer: 0 selects `id_mfr`, 1 selects `id_dev`, and any other value selects zero. The code is cut to the device width and copied into every device slice. The 82-entry limit and the mixed-width rule do not apply in this mode.
- R10: Lane i drives the low 7 bits of its offset on `rom_addr[7i+6:7i]` and takes the table byte from `rom_data[8i+7:8i]`. With a table holding "QRY" at offsets 0x10–0x12 and 0x01 at 0x13, those bytes appear in the responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_bank_lg | input | 2 | log2 of bank width in bytes |
| cfg_dev_lg | input | 2 | log2 of device operating width in bytes |
| cfg_max_lg | input | 2 | log2 of device native width in bytes |
| rd_en | input | 1 | Read strobe |
| rd_id_mode | input | 1 | 1 = identifier answer, 0 = table query |
| rd_size_lg | input | 2 | log2 of access size in bytes |
| rd_addr | input | 12 | Bus byte address |
| id_mfr | input | 16 | Manufacturer code |
| id_dev | input | 16 | Device code |
| rom_addr | output | 28 | Table offset, 7 bits per lane |
| rom_data | input | 32 | Table byte, 8 bits per lane |
| rd_data | output | 32 | Registered response |
| rd_valid | output | 1 | Response valid, one cycle after the strobe |

## Verification
The hardest situation to reach is a wide access over a narrow bank in mixed-width mode. There, several lanes fetch at different scaled offsets and one of them may fall past the table end while the others do not. The bench sweeps every legal width combination. For each one it walks addresses in steps of three across the whole range where offsets cross 82, with every access size in both modes, so lanes straddle the limit in both directions. After each reset release the width inputs are driven to an illegal code, so any logic that reads them live fails every comparison.

// File: rtl/flash_query_replicator.sv
`timescale 1ns/1ps
module flash_query_replicator #(
  parameter int ADDR_W      = 12,
  parameter int BUS_BYTES   = 4,
  parameter int TABLE_DEPTH = 82,
  parameter int CODE_W      = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        cfg_bank_lg,
  input  logic [1:0]                        cfg_dev_lg,
  input  logic [1:0]                        cfg_max_lg,
  input  logic                              rd_en,
  input  logic                              rd_id_mode,
  input  logic [1:0]                        rd_size_lg,
  input  logic [ADDR_W-1:0]                 rd_addr,
  input  logic [CODE_W-1:0]                 id_mfr,
  input  logic [CODE_W-1:0]                 id_dev,
  output logic [BUS_BYTES*$clog2(TABLE_DEPTH)-1:0] rom_addr,
  input  logic [BUS_BYTES*8-1:0]            rom_data,
  output logic [BUS_BYTES*8-1:0]            rd_data,
  output logic                              rd_valid
);
  localparam int DW     = BUS_BYTES * 8;
  localparam int ROM_AW = $clog2(TABLE_DEPTH);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(TABLE_DEPTH);

  logic [1:0] bank_lg, dev_lg, max_lg;
  logic [2:0] shamt;
  logic       mixed, unsup;
  int         bank_bytes, dev_bytes, acc_bytes;
  logic [DW-1:0] dev_mask, bank_mask, acc_mask, merged;
  logic [DW-1:0] lane_q [BUS_BYTES];
  logic          lane_in [BUS_BYTES];

  assign shamt      = 3'(bank_lg) + 3'(max_lg) - 3'(dev_lg);
  assign mixed      = dev_lg != max_lg;
  assign unsup      = mixed && (dev_lg != 2'd0);
  assign bank_bytes = 1 << bank_lg;
  assign dev_bytes  = 1 << dev_lg;
  assign acc_bytes  = 1 << rd_size_lg;
  assign dev_mask   = {DW{1'b1}} >> (DW - 8 * dev_bytes);
  assign bank_mask  = {DW{1'b1}} >> (DW - 8 * bank_bytes);
  assign acc_mask   = {DW{1'b1}} >> (DW - 8 * acc_bytes);

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    logic [ADDR_W-1:0] addr_l, off_l;
    logic [7:0]        tb;
    logic [DW-1:0]     raw, unit, rep;

    assign addr_l = rd_addr + (ADDR_W'(i) << bank_lg);
    assign off_l  = addr_l >> shamt;
    assign rom_addr[i*ROM_AW +: ROM_AW] = off_l[ROM_AW-1:0];
    assign tb     = rom_data[i*8 +: 8];
    assign lane_in[i] = off_l < LIMIT;

    always_comb begin
      if (rd_id_mode) begin
        if (off_l[7:0] == 8'd0)      raw = DW'(id_mfr);
        else if (off_l[7:0] == 8'd1) raw = DW'(id_dev);
        else                         raw = '0;
      end else if (unsup || !lane_in[i]) begin
        raw = '0;
      end else if (mixed) begin
        raw = {BUS_BYTES{tb}};
      end else begin
        raw = DW'(tb);
      end
      unit = raw & dev_mask;
      rep  = '0;
      for (int k = 0; k < BUS_BYTES; k++)
        if ((k % dev_bytes) == 0 && k < bank_bytes) rep = rep | (unit << (8 * k));
      if ((i * bank_bytes) < acc_bytes)
        lane_q[i] = (rep & bank_mask) << (8 * i * bank_bytes);
      else
        lane_q[i] = '0;
    end
  end

  always_comb begin
    merged = '0;
    for (int j = 0; j < BUS_BYTES; j++) merged = merged | lane_q[j];
    merged = merged & acc_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_lg  <= cfg_bank_lg;
      dev_lg   <= cfg_dev_lg;
      max_lg   <= cfg_max_lg;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= merged;
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R2
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R6
  unsup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_id_mode && unsup) |=> (rd_data == '0));
  // R4
  past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_id_mode && !lane_in[0] && (rd_size_lg <= bank_lg)) |=> (rd_data == '0));
  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ($stable(bank_lg) && $stable(dev_lg) && $stable(max_lg)));
endmodule

// File: tb/test_flash_query_replicator.sv
`timescale 1ns/1ps
module test_flash_query_replicator;
  localparam int AW = 12;
  localparam logic [15:0] MFR = 16'hA17C;
  localparam logic [15:0] DEV = 16'h3B95;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_bank_lg = '0, cfg_dev_lg = '0, cfg_max_lg = '0;
  logic rd_en = 1'b0, rd_id_mode = 1'b0;
  logic [1:0] rd_size_lg = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [27:0] rom_addr;
  logic [31:0] rom_data, rd_data;
  logic rd_valid;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  flash_query_replicator i_flash_query_replicator (
    .clk(clk), .rst_n(rst_n), .cfg_bank_lg(cfg_bank_lg), .cfg_dev_lg(cfg_dev_lg),
    .cfg_max_lg(cfg_max_lg), .rd_en(rd_en), .rd_id_mode(rd_id_mode),
    .rd_size_lg(rd_size_lg), .rd_addr(rd_addr), .id_mfr(MFR), .id_dev(DEV),
    .rom_addr(rom_addr), .rom_data(rom_data), .rd_data(rd_data), .rd_valid(rd_valid));

  function automatic logic [7:0] tbl(int k);
    case (k)
      16: return 8'h51;
      17: return 8'h52;
      18: return 8'h59;
      19: return 8'h01;
      20: return 8'h00;
      default: return 8'((k * 37 + 11) | 1);
    endcase
  endfunction

  always_comb
    for (int i = 0; i < 4; i++) rom_data[i*8 +: 8] = tbl(int'(rom_addr[i*7 +: 7]));

  function automatic logic [31:0] expect_rd(int bl, int dl, int ml, int sl, bit idm, int a);
    int bw, dw, acc, sh, j, p, q, off;
    logic [15:0] code;
    logic [7:0] v;
    logic [31:0] r;
    bw = 1 << bl; dw = 1 << dl; acc = 1 << sl; sh = bl + ml - dl;
    r = '0;
    for (int b = 0; b < 4; b++) begin
      if (b < acc) begin
        j = b / bw; p = b % bw; q = p % dw;
        off = ((a + j * bw) % 4096) >> sh;
        if (idm) begin
          code = ((off % 256) == 0) ? MFR : ((off % 256) == 1) ? DEV : 16'h0;
          v = (q < 2) ? code[8*q +: 8] : 8'h00;
        end else if ((dl != ml && dl != 0) || off >= 82) v = 8'h00;
        else if (dl != ml) v = tbl(off);
        else v = (q == 0) ? tbl(off) : 8'h00;
        r[8*b +: 8] = v;
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(int bl, int dl, int ml, int sl, bit idm, int a);
    @(negedge clk);
    rd_en = 1'b1; rd_id_mode = idm; rd_size_lg = 2'(sl); rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    // R3 R4 R5 R6 R7 R8 R9 R10 and R1 (cfg inputs scrambled)
    check("R3-scaled lookup", rd_data, expect_rd(bl, dl, ml, sl, idm, a));
    if (!rd_valid) check("R2 valid", {31'b0, rd_valid}, 32'd1);
  endtask

  task automatic apply_cfg(int bl, int dl, int ml);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_bank_lg = 2'(bl); cfg_dev_lg = 2'(dl); cfg_max_lg = 2'(ml);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cfg_bank_lg = 2'd3; cfg_dev_lg = 2'd3; cfg_max_lg = 2'd3;
  endtask

  initial begin
    logic [31:0] last;
    apply_cfg(0, 0, 0);
    // R2 reset state
    check("R2 reset valid", {31'b0, rd_valid}, 32'd0);
    check("R2 reset data", rd_data, 32'd0);
    // R10 signature bytes
    do_read(0, 0, 0, 2, 1'b0, 16);
    check("R10 QRY", rd_data, 32'h01595251);
    for (int bl = 0; bl < 3; bl++)
      for (int dl = 0; dl <= bl; dl++)
        for (int ml = dl; ml < 3; ml++) begin
          apply_cfg(bl, dl, ml);
          for (int a = 0; a < 1536; a += 3)
            for (int sl = 0; sl < 3; sl++)
              for (int m = 0; m < 2; m++) do_read(bl, dl, ml, sl, m[0], a);
          last = rd_data;
          @(negedge clk);
          // R2 idle cycle: no valid, data held
          check("R2 idle valid", {31'b0, rd_valid}, 32'd0);
          check("R2 idle hold", rd_data, last);
        end
    // R9 identifier in bank 4 / device 2
    apply_cfg(2, 1, 1);
    do_read(2, 1, 1, 2, 1'b1, 4);
    check("R9 device code", rd_data, {DEV, DEV});
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(195000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule